// File: doc/BRIEF.md
# 8x8 Block Inverse DCT Engine

This engine turns one 8x8 block of quantised frequency coefficients into 64 unsigned 8-bit pixels. Each input beat carries one row of eight raw coefficients and the matching row of eight quantiser values. The block dequantises each coefficient as it arrives and stores it in a 64-entry buffer. Once the block is complete, one combinational eight-point transform unit is used for every pass. It first processes the eight columns, writing each result back into the same buffer column. It then processes the eight rows of that buffer, which reads the column results in transposed order. Each row result is emitted as eight level-shifted pixels.

Both streaming edges use valid/ready handshakes. A beat is taken on a rising clock edge when valid and ready are both high. While valid is high and ready is low, the source must hold its data. The output side holds `out_valid` and `out_pix` steady until the sink raises `out_ready`, so the sink can stall for any number of cycles. Only one block is in flight at a time. The input side stays closed from the eighth input beat until the eighth output row has been taken.

The column pass has a shortcut. When every raw coefficient outside row 0 is zero, all eight columns are filled in a single cycle from row 0 instead of being transformed.

Top module: `blk_idct_engine`

## Requirements
- R1: Each dequantised value is the low 16 bits of the product of the 16-bit coefficient and the 16-bit quantiser, read as a signed 16-bit number. Overflow wraps around and does not saturate.
- R2: Input row r of a block is the r-th accepted beat. Coefficient k of that row sits in `in_coef[16k+15:16k]` and its quantiser sits in `in_quant[16k+15:16k]`. `in_ready` is low whenever `out_valid` is high, and a new block is accepted only after the eighth output row of the current block has been taken.
- R3: The eight-point transform uses 13-bit fixed-point constants. The even half forms (d0±d4)·2^13 and a rotation of d2 and d6 by 0.541196100, 0.765366865 and 1.847759065. The odd half combines d1, d3, d5 and d7 through the factors 0.298631336, 0.390180644, 0.899976223, 1.175875602, 1.501321110, 1.961570560, 2.053119869, 2.562915447 and 3.072711026, with each factor scaled by 8192 and rounded to an integer.
- R4: In the column pass, each result has 2^10 added, is shifted right arithmetically by 11 bits, and is clamped to the signed 16-bit range.
- R5: When every raw coefficient in rows 1 to 7 is zero, the column pass is skipped. Every entry of column c then becomes the dequantised row-0 value of that column shifted left by 2, wrapped to 16 bits and not clamped. The test uses the raw coefficients, so a nonzero raw value whose dequantised product wraps to zero still forces the full column pass.
- R6: The row pass runs on the 16-bit column results. Each result has 2^17 added, is shifted right arithmetically by 18 bits, is clamped to −128..127, and then has 128 added, giving 0..255.
- R7: Output rows leave in natural order, rows 0 to 7. Pixel k of a row sits in `out_pix[8k+7:8k]`.
- R8: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_pix` does not change on the next cycle.
- R9: `busy` is low after reset. It goes high with the first accepted input beat of a block and stays high until the handshake of that block's eighth output row.
- R10: Counting from the clock edge that takes the eighth input beat, `out_valid` rises 8 edges later when the full column pass runs and 1 edge later when the shortcut applies.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input row beat is valid |
| in_ready | output | 1 | Engine can take an input row |
| in_coef | input | 128 | Eight signed 16-bit raw coefficients, lane k at bits 16k |
| in_quant | input | 128 | Eight 16-bit quantiser values, lane k at bits 16k |
| out_valid | output | 1 | Output pixel row is valid |
| out_ready | input | 1 | Sink takes the output row |
| out_pix | output | 64 | Eight unsigned pixels, lane k at bits 8k |
| busy | output | 1 | A block is between its first input beat and its last output beat |

## Verification
A wrong entry in the coefficient buffer shows up in the very first output row when it is in row 0. Otherwise it shows up no later than the row it feeds. A column-pass error spreads into all eight pixels of every row, so a single row comparison exposes it. A wrong shortcut decision changes the pixels only when the DC value saturates or wraps. The bench therefore drives a large DC value, both alone and paired with a raw row coefficient that dequantises to zero. That same wrong decision also moves the rise of `out_valid` by seven cycles, which the latency check catches on the first row. Sequencing faults in the handshake show up as a lost or repeated row, or as `in_ready` high while `out_valid` is high.

// File: rtl/idct_pkg.sv
package idct_pkg;
  parameter int LANES   = 8;
  parameter int COEF_W  = 16;
  parameter int PIX_W   = 8;
  parameter int ACC_W   = 40;
  parameter int FRAC_W  = 13;
  parameter int COL_SH  = 11;
  parameter int ROW_SH  = 18;
  parameter int DC_SH   = 2;

  localparam int CNT_W  = $clog2(LANES);

  // 13-bit fixed-point rotation factors
  localparam int K0298 = 2446;
  localparam int K0390 = 3196;
  localparam int K0541 = 4433;
  localparam int K0765 = 6270;
  localparam int K0899 = 7373;
  localparam int K1175 = 9633;
  localparam int K1501 = 12299;
  localparam int K1847 = 15137;
  localparam int K1961 = 16069;
  localparam int K2053 = 16819;
  localparam int K2562 = 20995;
  localparam int K3072 = 25172;

  typedef enum logic [1:0] {ST_FILL, ST_COLS, ST_ROWS} eng_state_t;

  function automatic logic signed [COEF_W-1:0] clamp16(input logic signed [ACC_W-1:0] v);
    if (v > ACC_W'(32767))       return 16'sh7FFF;
    else if (v < -ACC_W'(32768)) return 16'sh8000;
    else                         return v[COEF_W-1:0];
  endfunction

  function automatic logic [PIX_W-1:0] to_pixel(input logic signed [ACC_W-1:0] v);
    logic [PIX_W-1:0] s;
    if (v > ACC_W'(127))       s = 8'h7F;
    else if (v < -ACC_W'(128)) s = 8'h80;
    else                       s = v[PIX_W-1:0];
    return {~s[PIX_W-1], s[PIX_W-2:0]};
  endfunction
endpackage

// File: rtl/idct_dq_row.sv
module idct_dq_row
  import idct_pkg::*;
#(
  parameter int N = LANES,
  parameter int W = COEF_W
) (
  input  logic [N*W-1:0] coef_i,
  input  logic [N*W-1:0] qnt_i,
  output logic [N*W-1:0] dq_o,
  output logic           nz_o
);
  logic [N-1:0] lane_nz;

  for (genvar k = 0; k < N; k++) begin : g_lane
    // low half of the product only (wraps)
    assign dq_o[k*W +: W] = coef_i[k*W +: W] * qnt_i[k*W +: W];
    assign lane_nz[k]     = |coef_i[k*W +: W];
  end

  assign nz_o = |lane_nz;
endmodule

// File: rtl/idct_1d.sv
module idct_1d
  import idct_pkg::*;
#(
  parameter int IN_W = COEF_W,
  parameter int W    = ACC_W
) (
  input  logic [LANES*IN_W-1:0] vec_i,
  input  logic                  late_i,
  output logic [LANES*W-1:0]    res_o
);
  localparam logic signed [W-1:0] C_E2A = W'(K0541);
  localparam logic signed [W-1:0] C_E2B = W'(K0541 - K1847);
  localparam logic signed [W-1:0] C_E3A = W'(K0541 + K0765);
  localparam logic signed [W-1:0] C_M3A = W'(K1175 - K1961);
  localparam logic signed [W-1:0] C_MID = W'(K1175);
  localparam logic signed [W-1:0] C_M4B = W'(K1175 - K0390);
  localparam logic signed [W-1:0] C_O0  = W'(K0298 - K0899);
  localparam logic signed [W-1:0] C_O1  = W'(K2053 - K2562);
  localparam logic signed [W-1:0] C_O2  = W'(K3072 - K2562);
  localparam logic signed [W-1:0] C_O3  = W'(K1501 - K0899);
  localparam logic signed [W-1:0] C_N89 = W'(K0899);
  localparam logic signed [W-1:0] C_N256 = W'(K2562);
  localparam logic signed [W-1:0] HALF_C = W'(1) <<< (COL_SH - 1);
  localparam logic signed [W-1:0] HALF_R = W'(1) <<< (ROW_SH - 1);

  logic signed [W-1:0] x [LANES];
  logic signed [W-1:0] raw [LANES];
  logic signed [W-1:0] ev0, ev1, ev2, ev3, s10, s11, s12, s13;
  logic signed [W-1:0] z3, z4, m3, m4, od0, od1, od2, od3;

  for (genvar k = 0; k < LANES; k++) begin : g_in
    assign x[k] = {{(W-IN_W){vec_i[k*IN_W+IN_W-1]}}, vec_i[k*IN_W +: IN_W]};
  end

  always_comb begin
    // even half
    ev0 = (x[0] + x[4]) <<< FRAC_W;
    ev1 = (x[0] - x[4]) <<< FRAC_W;
    ev2 = x[2] * C_E2A + x[6] * C_E2B;
    ev3 = x[2] * C_E3A + x[6] * C_E2A;
    s10 = ev0 + ev3;
    s13 = ev0 - ev3;
    s11 = ev1 + ev2;
    s12 = ev1 - ev2;
    // odd half
    z3  = x[7] + x[3];
    z4  = x[5] + x[1];
    m3  = z3 * C_M3A + z4 * C_MID;
    m4  = z3 * C_MID + z4 * C_M4B;
    od0 = x[7] * C_O0 - x[1] * C_N89 + m3;
    od1 = x[5] * C_O1 - x[3] * C_N256 + m4;
    od2 = x[3] * C_O2 - x[5] * C_N256 + m3;
    od3 = x[1] * C_O3 - x[7] * C_N89 + m4;
    // butterfly
    raw[0] = s10 + od3;
    raw[7] = s10 - od3;
    raw[1] = s11 + od2;
    raw[6] = s11 - od2;
    raw[2] = s12 + od1;
    raw[5] = s12 - od1;
    raw[3] = s13 + od0;
    raw[4] = s13 - od0;
  end

  for (genvar k = 0; k < LANES; k++) begin : g_out
    assign res_o[k*W +: W] = late_i ? ((raw[k] + HALF_R) >>> ROW_SH)
                                    : ((raw[k] + HALF_C) >>> COL_SH);
  end
endmodule

// File: rtl/blk_idct_engine.sv
module blk_idct_engine
  import idct_pkg::*;
(
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  output logic                    in_ready,
  input  logic [LANES*COEF_W-1:0] in_coef,
  input  logic [LANES*COEF_W-1:0] in_quant,
  output logic                    out_valid,
  input  logic                    out_ready,
  output logic [LANES*PIX_W-1:0]  out_pix,
  output logic                    busy
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(LANES - 1);

  eng_state_t                state_q;
  logic [CNT_W-1:0]          cnt_q;
  logic                      ac_nz_q;
  logic signed [COEF_W-1:0]  mem_q [LANES][LANES];

  logic [LANES*COEF_W-1:0]   dq_row;
  logic                      row_nz;
  logic [LANES*COEF_W-1:0]   col_vec, row_vec;
  logic [LANES*ACC_W-1:0]    xf_res;
  logic                      in_fire, out_fire, row_last;

  assign in_ready  = (state_q == ST_FILL);
  assign out_valid = (state_q == ST_ROWS);
  assign in_fire   = in_valid && in_ready;
  assign out_fire  = out_valid && out_ready;
  assign row_last  = (cnt_q == LAST);
  assign busy      = (state_q != ST_FILL) || (cnt_q != '0);

  idct_dq_row u_dq (
    .coef_i (in_coef),
    .qnt_i  (in_quant),
    .dq_o   (dq_row),
    .nz_o   (row_nz)
  );

  for (genvar k = 0; k < LANES; k++) begin : g_sel
    assign col_vec[k*COEF_W +: COEF_W] = mem_q[k][cnt_q];
    assign row_vec[k*COEF_W +: COEF_W] = mem_q[cnt_q][k];
    assign out_pix[k*PIX_W +: PIX_W]   = to_pixel(xf_res[k*ACC_W +: ACC_W]);
  end

  // one shared eight-point unit for both passes
  idct_1d u_xf (
    .vec_i  ((state_q == ST_COLS) ? col_vec : row_vec),
    .late_i (state_q == ST_ROWS),
    .res_o  (xf_res)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_FILL;
      cnt_q   <= '0;
      ac_nz_q <= 1'b0;
      for (int r = 0; r < LANES; r++)
        for (int c = 0; c < LANES; c++)
          mem_q[r][c] <= '0;
    end else begin
      unique case (state_q)
        ST_FILL: if (in_fire) begin
          for (int c = 0; c < LANES; c++)
            mem_q[cnt_q][c] <= dq_row[c*COEF_W +: COEF_W];
          ac_nz_q <= (cnt_q == '0) ? 1'b0 : (ac_nz_q | row_nz);
          cnt_q   <= cnt_q + 1'b1;
          if (row_last) state_q <= ST_COLS;
        end
        ST_COLS: begin
          if (!ac_nz_q) begin
            // DC-only block: broadcast row 0 scaled, wraps
            for (int r = 0; r < LANES; r++)
              for (int c = 0; c < LANES; c++)
                mem_q[r][c] <= mem_q[0][c] <<< DC_SH;
            cnt_q   <= '0;
            state_q <= ST_ROWS;
          end else begin
            for (int r = 0; r < LANES; r++)
              mem_q[r][cnt_q] <= clamp16(xf_res[r*ACC_W +: ACC_W]);
            cnt_q <= cnt_q + 1'b1;
            if (row_last) state_q <= ST_ROWS;
          end
        end
        ST_ROWS: if (out_fire) begin
          cnt_q <= cnt_q + 1'b1;
          if (row_last) state_q <= ST_FILL;
        end
        default: state_q <= ST_FILL;
      endcase
    end
  end

  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_pix)));

  p_release_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (out_fire && row_last) |=> in_ready);

  p_busy_rise_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(in_valid && in_ready));

  p_busy_fall_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(out_valid && out_ready));

  p_skip_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_COLS && !ac_nz_q) |=> out_valid);

  p_full_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_COLS && ac_nz_q && !row_last) |=> !out_valid && !in_ready);
endmodule

// File: tb/blk_idct_engine_bench.sv
`timescale 1ns/1ps
module blk_idct_engine_bench;
  logic         clk = 1'b0;
  logic         rst_n;
  logic         in_valid;
  logic         in_ready;
  logic [127:0] in_coef;
  logic [127:0] in_quant;
  logic         out_valid;
  logic         out_ready;
  logic [63:0]  out_pix;
  logic         busy;

  always #10 clk = ~clk;

  blk_idct_engine u_blk_idct_engine (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_coef(in_coef), .in_quant(in_quant), .out_valid(out_valid),
    .out_ready(out_ready), .out_pix(out_pix), .busy(busy)
  );

  typedef struct { logic [63:0] pix; string tag; int row; } exp_t;
  exp_t exp_q[$];
  int   lat_q[$];
  int   acc_q[$];
  int   checks = 0;
  int   errors = 0;
  int   cyc = 0;
  int   bp_mode = 0;
  bit   lat_done = 0;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic longint w16(input longint v);
    return longint'(shortint'(v));
  endfunction
  function automatic longint clampv(input longint v, input longint lo, input longint hi);
    return (v < lo) ? lo : ((v > hi) ? hi : v);
  endfunction
  function automatic longint rsh(input longint v, input int s);
    return (v + (longint'(1) <<< (s - 1))) >>> s;
  endfunction

  function automatic void ref_1d(input longint x[8], output longint y[8]);
    longint e0, e1, e2, e3, a10, a11, a12, a13, z3, z4, m3, m4, o0, o1, o2, o3;
    e0 = (x[0] + x[4]) * 8192;
    e1 = (x[0] - x[4]) * 8192;
    e2 = x[2] * 4433 + x[6] * (4433 - 15137);
    e3 = x[2] * (4433 + 6270) + x[6] * 4433;
    a10 = e0 + e3; a13 = e0 - e3; a11 = e1 + e2; a12 = e1 - e2;
    z3 = x[7] + x[3]; z4 = x[5] + x[1];
    m3 = z3 * (9633 - 16069) + z4 * 9633;
    m4 = z3 * 9633 + z4 * (9633 - 3196);
    o0 = x[7] * (2446 - 7373) - x[1] * 7373 + m3;
    o1 = x[5] * (16819 - 20995) - x[3] * 20995 + m4;
    o2 = x[3] * (25172 - 20995) - x[5] * 20995 + m3;
    o3 = x[1] * (12299 - 7373) - x[7] * 7373 + m4;
    y[0] = a10 + o3; y[7] = a10 - o3;
    y[1] = a11 + o2; y[6] = a11 - o2;
    y[2] = a12 + o1; y[5] = a12 - o1;
    y[3] = a13 + o0; y[4] = a13 - o0;
  endfunction

  task automatic send_block(input int c[64], input int q[64], input string tag);
    longint dq[64], mid[64], x[8], y[8];
    bit sc = 1;
    exp_t e;
    for (int k = 0; k < 64; k++) begin
      dq[k] = w16(longint'(c[k]) * longint'(q[k]));   // R1
      if (k >= 8 && shortint'(c[k]) != 0) sc = 0;     // R5 raw test
    end
    for (int col = 0; col < 8; col++) begin
      if (sc) begin
        for (int r = 0; r < 8; r++) mid[r*8+col] = w16(dq[col] * 4);
      end else begin
        for (int r = 0; r < 8; r++) x[r] = dq[r*8+col];
        ref_1d(x, y);
        for (int r = 0; r < 8; r++) mid[r*8+col] = clampv(rsh(y[r], 11), -32768, 32767);
      end
    end
    for (int r = 0; r < 8; r++) begin
      for (int k = 0; k < 8; k++) x[k] = mid[r*8+k];
      ref_1d(x, y);
      for (int k = 0; k < 8; k++) e.pix[k*8 +: 8] = 8'(clampv(rsh(y[k], 18), -128, 127) + 128);
      e.tag = tag; e.row = r;
      exp_q.push_back(e);
    end
    lat_q.push_back(sc ? 1 : 8);
    for (int r = 0; r < 8; r++) begin
      @(negedge clk);
      in_valid = 1'b1;
      for (int k = 0; k < 8; k++) begin
        in_coef[k*16 +: 16]  = 16'(c[r*8+k]);
        in_quant[k*16 +: 16] = 16'(q[r*8+k]);
      end
      while (!in_ready) @(negedge clk);
      if (r == 7) acc_q.push_back(cyc + 1);
    end
    @(negedge clk);
    in_valid = 1'b0;
    checks++;
    if (!busy) begin
      errors++;
      $display("FAIL R9 busy after input beats: actual %0b expected 1", busy);
    end
  endtask

  always @(negedge clk) begin
    bit rdy;
    exp_t e;
    rdy = (bp_mode != 0) ? ($urandom_range(0, 2) != 0) : 1'b1;
    out_ready = rdy;
    if (rst_n && out_valid) begin
      checks++;
      if (in_ready) begin
        errors++;
        $display("FAIL R2 in_ready while out_valid: actual 1 expected 0");
      end
      if (!lat_done) begin
        int got, want;
        lat_done = 1;
        got = cyc - acc_q.pop_front();
        want = lat_q.pop_front();
        checks++;
        if (got != want) begin
          errors++;
          $display("FAIL R10 latency: actual %0d expected %0d", got, want);
        end
      end
      if (rdy) begin
        checks++;
        if (exp_q.size() == 0) begin
          errors++;
          $display("FAIL R7 unexpected row: actual %h expected none", out_pix);
        end else begin
          e = exp_q.pop_front();
          if (out_pix !== e.pix) begin
            errors++;
            $display("FAIL R6/R7 [%s] row %0d: actual %h expected %h", e.tag, e.row, out_pix, e.pix);
          end
          if (e.row == 7) lat_done = 0;
        end
      end
    end
  end

  initial begin
    #3000000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int c[64], q[64];
    rst_n = 1'b0; in_valid = 1'b0; in_coef = '0; in_quant = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    checks++;
    if (busy || !in_ready || out_valid) begin
      errors++;
      $display("FAIL R9 reset state busy/in_ready/out_valid: actual %0b%0b%0b expected 010",
               busy, in_ready, out_valid);
    end

    // R5 DC-only block
    for (int k = 0; k < 64; k++) begin c[k] = 0; q[k] = 4; end
    c[0] = 80; c[3] = -20;
    send_block(c, q, "R5 dc only");

    // R3/R4 small full block
    for (int k = 0; k < 64; k++) begin c[k] = $urandom_range(0, 40) - 20; q[k] = $urandom_range(1, 8); end
    send_block(c, q, "R3 R4 full");

    // R5 shortcut wraps a large DC
    for (int k = 0; k < 64; k++) begin c[k] = 0; q[k] = 1; end
    c[0] = 10000;
    send_block(c, q, "R5 dc wrap");

    // R5 raw nonzero that dequantises to zero forces the full pass
    c[24] = 256; q[24] = 256;
    send_block(c, q, "R5 raw test");

    // R1 dequant wrap
    for (int k = 0; k < 64; k++) begin c[k] = (k % 3 == 0) ? 300 - k : 0; q[k] = 300; end
    send_block(c, q, "R1 wrap");

    // R6 saturation with large values, back-pressure on
    bp_mode = 1;
    for (int k = 0; k < 64; k++) begin c[k] = $urandom_range(0, 4000) - 2000; q[k] = $urandom_range(1, 60); end
    send_block(c, q, "R6 saturate");

    for (int b = 0; b < 6; b++) begin
      for (int k = 0; k < 64; k++) begin
        c[k] = (k < 8 || $urandom_range(0, 3) == 0) ? int'($urandom_range(0, 200)) - 100 : 0;
        q[k] = $urandom_range(1, 16);
      end
      send_block(c, q, "R8 backpressure");
    end

    while (exp_q.size() != 0) @(negedge clk);
    @(negedge clk);
    checks++;
    if (busy || !in_ready) begin
      errors++;
      $display("FAIL R9 idle after last row busy/in_ready: actual %0b%0b expected 01", busy, in_ready);
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule